// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block owns the output latch of one quasi-bidirectional I/O port and turns it into three per-pin drive enables for a pad: a pull-down, a short strong pull-up and a weak keeper pull-up. A pin holding 0 is pulled down. When a pin goes from 0 to 1, the strong pull-up fires for a fixed number of clock periods to charge the line quickly. The weak keeper then holds the 1, so an outside source can still pull the pin low and the pin works as an input. The block runs on the oscillator clock.

During an external memory access that uses a 16-bit pointer, the port can carry the high address byte instead of its latch. Every address bit that is 1 keeps its strong pull-up on for the whole access. When the access ends, the pins go back to the latch contents. An access that uses an 8-bit register-indirect address leaves the latch on the pins. Power-down always puts the latch value back on the pins. Two read paths are provided: the latch itself, for read-modify-write, and the pin level after a synchroniser, for plain reads.

Top module: `qbd_port_driver`

## Requirements
- R1: While `rst_n` is low, `latch_q` is all ones at once, with no clock edge needed. After reset, every pin shows the weak enable only.
- R2: For every pin whose driven value is 0, `pd_en` is 1 and both `strong_en` and `weak_en` are 0.
- R3: A 0-to-1 change of a pin's driven value asserts `strong_en` for exactly STRONG_CYCLES (default 2) clock periods. The first of these is the cycle in which the new value appears.
- R4: After the strong pulse, a pin driven to 1 shows `weak_en` only. Writing 1 over a latch bit that is already 1 produces no strong pulse.
- R5: When `addr_mode`=1 and `access_act`=1 and `pwr_down`=0, the pins carry `bus_addr_hi`. Every 1 bit holds `strong_en` for the whole access, and every 0 bit holds `pd_en`.
- R6: When `access_act`=1 with `addr_mode`=0 (8-bit indirect access), the pins carry the latch contents, whatever `bus_addr_hi` holds.
- R7: When the address access ends, the pins carry the latch again. Bits that go from 0 to 1 at that point get a fresh STRONG_CYCLES-period pulse.
- R8: `pwr_down`=1 forces the pins to the latch value, even while an address access is flagged.
- R9: A write strobe `wr_en` loads `wr_data` into the latch on the clock edge. `latch_q` returns the latch, unaffected by address mode.
- R10: `pin_sync` returns `pin_in` delayed by SYNC_STAGES (default 2) clock edges.
- R11: If a new 0-to-1 change occurs after a pulse was cut short by a 0, the count restarts from the beginning.
- R12: For every pin, exactly one of `pd_en`, `strong_en` and `weak_en` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port register write strobe |
| wr_data | input | W | Write data |
| addr_mode | input | 1 | 1: external access drives the high address byte |
| access_act | input | 1 | External access in progress |
| pwr_down | input | 1 | Power-down state |
| bus_addr_hi | input | W | External-bus high address byte |
| pin_in | input | W | Pin levels from the pad |
| pd_en | output | W | Pull-down enables |
| strong_en | output | W | Strong pull-up enables |
| weak_en | output | W | Weak keeper pull-up enables |
| latch_q | output | W | Latch contents, for read-modify-write |
| pin_sync | output | W | Synchronised pin levels |

## Verification
The hardest case to reach is a strong pulse that is cut short and then started again. The stimulus writes 1, writes 0 in the very next cycle, and then writes 1 again. This checks that the second pulse lasts the full period count and does not pick up a leftover count. The other hard case is the end of an address access. The bench leaves the address on the pins long enough to settle, then drops `access_act`. It then checks that only the bits going from 0 to 1 receive the new pulse, and that bits which stay 1 go straight to the keeper.

// File: rtl/qbd_port_driver.sv
module qbd_port_driver #(
  parameter int W             = 8,
  parameter int STRONG_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         addr_mode,
  input  logic         access_act,
  input  logic         pwr_down,
  input  logic [W-1:0] bus_addr_hi,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] strong_en,
  output logic [W-1:0] weak_en,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] pin_sync
);
  localparam int CW = $clog2(STRONG_CYCLES + 1);

  logic         bus_drive;
  logic [W-1:0] drv, drv_q, rise, hold, addr_hold;
  logic [W-1:0] sync_q [SYNC_STAGES];

  assign bus_drive = addr_mode & access_act & ~pwr_down;
  assign drv       = bus_drive ? bus_addr_hi : latch_q;
  assign rise      = drv & ~drv_q;
  assign addr_hold = bus_drive ? bus_addr_hi : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     latch_q <= '1;
    else if (wr_en) latch_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) drv_q <= '1;
    else        drv_q <= drv;

  for (genvar i = 0; i < W; i++) begin : g_pulse
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (rise[i])    cnt <= CW'(STRONG_CYCLES - 1);
      else if (!drv[i])    cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    assign hold[i] = (cnt != '0);
  end

  assign strong_en = drv & (rise | hold | addr_hold);
  assign pd_en     = ~drv;
  assign weak_en   = drv & ~strong_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end

  assign pin_sync = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/qbd_port_driver_chk.sv
module qbd_port_driver_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         addr_mode,
  input logic         access_act,
  input logic         pwr_down,
  input logic [W-1:0] bus_addr_hi,
  input logic [W-1:0] pd_en,
  input logic [W-1:0] strong_en,
  input logic [W-1:0] weak_en,
  input logic [W-1:0] latch_q
);
  logic addr_on;
  assign addr_on = addr_mode & access_act & ~pwr_down;

  always @(posedge clk)
    if (!rst_n) AST_RESET_ONES: assert (latch_q == '1); // R1

  AST_ZERO_PULLS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_on |-> (pd_en == ~latch_q)); // R2

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_on && $past(!addr_on) && $past(!addr_on, 2)) |->
      ((strong_en & $past(strong_en) & $past(strong_en, 2)) == '0)); // R3

  AST_ADDR_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
    addr_on |-> (strong_en == bus_addr_hi)); // R5

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (latch_q == $past(wr_data))); // R9

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_en & strong_en) == '0) && ((pd_en & weak_en) == '0) &&
    ((strong_en & weak_en) == '0) && ((pd_en | strong_en | weak_en) == '1)); // R12
endmodule

bind qbd_port_driver qbd_port_driver_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .addr_mode(addr_mode), .access_act(access_act), .pwr_down(pwr_down),
  .bus_addr_hi(bus_addr_hi), .pd_en(pd_en), .strong_en(strong_en),
  .weak_en(weak_en), .latch_q(latch_q)
);

// File: tb/tb_qbd_port_driver.sv
module tb_qbd_port_driver;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, addr_mode, access_act, pwr_down;
  logic [7:0] wr_data, bus_addr_hi, pin_in;
  logic [7:0] pd_en, strong_en, weak_en, latch_q, pin_sync;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  qbd_port_driver dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .addr_mode(addr_mode), .access_act(access_act), .pwr_down(pwr_down),
    .bus_addr_hi(bus_addr_hi), .pin_in(pin_in), .pd_en(pd_en),
    .strong_en(strong_en), .weak_en(weak_en), .latch_q(latch_q),
    .pin_sync(pin_sync)
  );

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'hF0, 8'hF0, 8'h0F, 8'h3C};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    rst_n = 1'b1; wr_en = 1'b0; wr_data = '0; addr_mode = 1'b0;
    access_act = 1'b0; pwr_down = 1'b0; bus_addr_hi = '0; pin_in = 8'hFF;
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset latch", latch_q, 8'hFF);
    chk("R1 reset weak", weak_en, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    prev = 8'hFF;
    foreach (VEC[n]) begin
      wr(VEC[n]);
      chk("R9 latch", latch_q, VEC[n]);
      chk("R2 pd", pd_en, ~VEC[n]);
      chk("R3 strong c0", strong_en, VEC[n] & ~prev);
      chk("R4 weak c0", weak_en, VEC[n] & prev);
      @(negedge clk);
      chk("R3 strong c1", strong_en, VEC[n] & ~prev);
      @(negedge clk);
      chk("R3 strong c2", strong_en, 8'h00);
      chk("R4 weak c2", weak_en, VEC[n]);
      prev = VEC[n];
    end

    // R11 restart after a pulse is cut short
    wr(8'h00); settle();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_data = 8'h00;
    chk("R11 first pulse", strong_en, 8'h01);
    @(negedge clk); wr_data = 8'h01;
    chk("R11 cut to pd", pd_en, 8'hFF);
    @(negedge clk); wr_en = 1'b0;
    chk("R11 restart c0", strong_en, 8'h01);
    @(negedge clk);
    chk("R11 restart c1", strong_en, 8'h01);
    @(negedge clk);
    chk("R11 restart end", strong_en, 8'h00);

    // R5 / R7 address access
    wr(8'h0F); settle();
    addr_mode = 1'b1; access_act = 1'b1; bus_addr_hi = 8'hA5;
    #1 chk("R5 strong now", strong_en, 8'hA5);
    chk("R5 pd now", pd_en, 8'h5A);
    repeat (4) @(negedge clk);
    chk("R5 strong held", strong_en, 8'hA5);
    chk("R9 latch kept", latch_q, 8'h0F);
    access_act = 1'b0;
    #1 chk("R7 pulse c0", strong_en, 8'h0A);
    chk("R7 weak c0", weak_en, 8'h05);
    chk("R7 pd c0", pd_en, 8'hF0);
    @(negedge clk);
    chk("R7 pulse c1", strong_en, 8'h0A);
    @(negedge clk);
    chk("R7 pulse end", weak_en, 8'h0F);

    // R6 indirect access leaves latch on pins
    addr_mode = 1'b0; access_act = 1'b1; bus_addr_hi = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R6 pd", pd_en, 8'hF0);
    chk("R6 strong", strong_en, 8'h00);

    // R8 power-down overrides address mode
    addr_mode = 1'b1; pwr_down = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 pd", pd_en, 8'hF0);
    chk("R8 weak", weak_en, 8'h0F);
    addr_mode = 1'b0; access_act = 1'b0; pwr_down = 1'b0;

    // R10 synchroniser delay
    settle();
    pin_in = 8'h3C;
    @(negedge clk);
    chk("R10 one edge", pin_sync, 8'hFF);
    @(negedge clk);
    chk("R10 two edges", pin_sync, 8'h3C);

    // R12 per-pin exclusivity on a mixed pattern
    wr(8'h96);
    chk("R12 cover", pd_en | strong_en | weak_en, 8'hFF);
    chk("R12 disjoint", (pd_en & strong_en) | (pd_en & weak_en) | (strong_en & weak_en), 8'h00);

    // R1 async reset without a clock edge
    wr(8'h00); settle();
    #3 rst_n = 1'b0;
    #1 chk("R1 async", latch_q, 8'hFF);
    rst_n = 1'b1;
    settle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule